// File: doc/BRIEF.md
# Memory-Mapped DMA Controller

This block is a bus-master copy engine. Software programs a source pointer, a destination pointer, an element count and an element conversion through four 32-bit registers. The engine then moves the elements one at a time. Each element is a read on a request/acknowledge master port followed by a write on the same port. A transfer starts when software writes the transfer-type register. In automatic mode it starts instead on an event from one of sixteen interrupt lines, and that event can be a rising edge or a high level.

An element is a byte or a word. A byte can be stored as a byte, or widened to a word with zero-extension or with sign-extension. The pointers and the count keep moving while a transfer runs, and reading the registers shows them as they are. The engine reports completion and bus errors through sticky status bits in the control register. It can also emit a single-cycle fence pulse after a clean completion.

Top module: `xdma_top`

## Requirements
- R1: After reset every register reads zero and `busReq` is low.
- R2: The register word index `cfgIdx` selects the register: 0 is control, 1 is the source pointer, 2 is the destination pointer and 3 is transfer type. Control holds enable in bit 0, automatic mode in bit 1, fence request in bit 2, trigger level in bit 15 (0 = rising edge, 1 = high level) and the trigger channel in bits 19:16. Transfer type holds the count in bits 23:0, the conversion in bits 28:27, source increment in bit 29 and destination increment in bit 30. Control bits 7:3, 14:11 and 31:20 read as zero. Transfer-type bits 26:24 and 31 read as zero.
- R3: When the block is enabled and in manual mode, writing transfer type with a non-zero count while idle starts a copy of that many elements. Control bit 8 (busy) is high while the copy runs. Bit 9 (done) is set when it finishes.
- R4: Conversion codes are: 00 moves a byte to a byte, 01 widens a byte to a zero-extended word, 10 widens a byte to a sign-extended word, and 11 moves a word to a word. A read byte is taken from `busRdata[7:0]`. A byte write carries the value in `busWdata[7:0]` with the upper bits zero. `busWord` is high for a word access.
- R5: A pointer whose increment bit is set steps by 1 after a byte access and by 4 after a word access. A pointer whose increment bit is clear stays on the same address.
- R6: Reading the pointers returns their live values. Count bits 23:0 read back the number of elements still to move.
- R7: In automatic edge mode, only a 0-to-1 change on the selected line starts a transfer. A line that is already high, or a line on another channel, does nothing.
- R8: In automatic level mode, a high selected line starts a transfer whenever the remaining count is non-zero.
- R9: `busErr` stops the transfer at once. It sets sticky control bit 10, leaves the pointers and the count at the failing element, and produces no fence pulse.
- R10: `fencePulse` is high for exactly one cycle after a transfer completes cleanly, and only when control bit 2 is set.
- R11: Writes to the pointers and to transfer type while busy are ignored.
- R12: `busReq`, `busWe` and `busAddr` stay constant from the start of a request until it is acknowledged or errored.
- R13: Starting a new transfer clears the done and error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgIdx | input | 2 | Register word index |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Register read data (combinational) |
| irqLines | input | 16 | Trigger interrupt lines |
| busReq | output | 1 | Master request, held until ack or error |
| busWe | output | 1 | 1 = write, 0 = read |
| busWord | output | 1 | 1 = word access, 0 = byte access |
| busAddr | output | 32 | Byte address |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data |
| busAck | input | 1 | Access completed |
| busErr | input | 1 | Access failed |
| fencePulse | output | 1 | Single-cycle fence request |

## Verification
Most faults in the pointer or counter state show up as a misplaced or missing byte in the target memory. They also show up in the live readback of the registers as soon as the transfer ends. A stepping fault is visible after the first element. A fault in the sequencer shows up within one access, as a request that drops or changes address before its acknowledge, or as a stray or repeated fence pulse. A trigger fault appears as a count that moves when it should not, or stays put when it should move, within a few cycles of the line changing.

// File: rtl/xdma_pkg.sv
package xdma_pkg;

  typedef enum logic [1:0] {
    CONV_B2B  = 2'b00,
    CONV_B2ZW = 2'b01,
    CONV_B2SW = 2'b10,
    CONV_W2W  = 2'b11
  } conv_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE
  } state_e;

  // strobes from the sequencer to the pointer/data path
  typedef struct packed {
    logic ldSrc;
    logic ldDst;
    logic ldCnt;
    logic capData;
    logic step;
  } dp_strobe_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_SRC  = 2'd1;
  localparam logic [1:0] REG_DST  = 2'd2;
  localparam logic [1:0] REG_TYPE = 2'd3;

endpackage

// File: rtl/xdma_datapath.sv
module xdma_datapath
  import xdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_strobe_t    strobe,
  input  logic [31:0]   wrData,
  input  conv_e         conv,
  input  logic          srcInc,
  input  logic          dstInc,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] srcPtr,
  output logic [AW-1:0] dstPtr,
  output logic [CW-1:0] remain,
  output logic [DW-1:0] wrWord
);

  localparam int BW = 8;
  localparam int WORD_BYTES = DW / BW;

  logic [DW-1:0] dataReg;
  logic [AW-1:0] srcStep;
  logic [AW-1:0] dstStep;

  // source reads are word sized only for word-to-word; destination writes
  // are byte sized only for byte-to-byte
  assign srcStep = (conv == CONV_W2W) ? AW'(WORD_BYTES) : AW'(1);
  assign dstStep = (conv == CONV_B2B) ? AW'(1) : AW'(WORD_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPtr  <= '0;
      dstPtr  <= '0;
      remain  <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.ldSrc) srcPtr <= wrData[AW-1:0];
      else if (strobe.step && srcInc) srcPtr <= srcPtr + srcStep;

      if (strobe.ldDst) dstPtr <= wrData[AW-1:0];
      else if (strobe.step && dstInc) dstPtr <= dstPtr + dstStep;

      if (strobe.ldCnt) remain <= wrData[CW-1:0];
      else if (strobe.step) remain <= remain - CW'(1);

      if (strobe.capData) dataReg <= busRdata;
    end
  end

  always_comb begin
    unique case (conv)
      CONV_B2B, CONV_B2ZW: wrWord = DW'(dataReg[BW-1:0]);
      CONV_B2SW:           wrWord = {{(DW-BW){dataReg[BW-1]}}, dataReg[BW-1:0]};
      default:             wrWord = dataReg;
    endcase
  end

  // R6
  remain_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> remain == $past(remain) - CW'(1));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> !(strobe.ldSrc || strobe.ldDst || strobe.ldCnt));

endmodule

// File: rtl/xdma_ctrl.sv
module xdma_ctrl
  import xdma_pkg::*;
#(
  parameter int CW  = 24,
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWrEn,
  input  logic [1:0]     cfgIdx,
  input  logic [31:0]    cfgWrData,
  input  logic [NCH-1:0] irqLines,
  input  logic           busAck,
  input  logic           busErr,
  input  logic [CW-1:0]  remain,
  output dp_strobe_t     strobe,
  output conv_e          conv,
  output logic           srcInc,
  output logic           dstInc,
  output logic           busReq,
  output logic           busWe,
  output logic           busWord,
  output logic           fencePulse,
  output logic [31:0]    ctrlWord
);

  localparam int SEL_W = $clog2(NCH);

  state_e          state;
  logic            enBit, autoBit, fenceBit, lvlBit;
  logic [SEL_W-1:0] selR;
  logic [NCH-1:0]  irqPrev;
  logic            doneFlag, errFlag;
  logic            busy, idleWr, trigHit, swStart, hwStart, startGo;
  logic            lastElem;
  logic            unusedBits;

  assign unusedBits = ^{cfgWrData[31], cfgWrData[26:24]};

  assign busy    = (state != ST_IDLE);
  assign idleWr  = cfgWrEn && !busy;
  assign trigHit = lvlBit ? irqLines[selR] : (irqLines[selR] && !irqPrev[selR]);
  assign swStart = idleWr && (cfgIdx == REG_TYPE) && enBit && !autoBit &&
                   (cfgWrData[CW-1:0] != '0);
  assign hwStart = !busy && !cfgWrEn && enBit && autoBit && (remain != '0) && trigHit;
  assign startGo = swStart || hwStart;
  assign lastElem = (remain == CW'(1));

  always_comb begin
    strobe.ldSrc   = idleWr && (cfgIdx == REG_SRC);
    strobe.ldDst   = idleWr && (cfgIdx == REG_DST);
    strobe.ldCnt   = idleWr && (cfgIdx == REG_TYPE);
    strobe.capData = (state == ST_READ) && busAck && !busErr;
    strobe.step    = (state == ST_WRITE) && busAck && !busErr;
  end

  assign busReq  = busy;
  assign busWe   = (state == ST_WRITE);
  assign busWord = (state == ST_WRITE) ? (conv != CONV_B2B) : (conv == CONV_W2W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      autoBit  <= 1'b0;
      fenceBit <= 1'b0;
      lvlBit   <= 1'b0;
      selR     <= '0;
      conv     <= CONV_B2B;
      srcInc   <= 1'b0;
      dstInc   <= 1'b0;
      irqPrev  <= '0;
    end else begin
      irqPrev <= irqLines;
      if (cfgWrEn && cfgIdx == REG_CTRL) begin
        enBit    <= cfgWrData[0];
        autoBit  <= cfgWrData[1];
        fenceBit <= cfgWrData[2];
        lvlBit   <= cfgWrData[15];
        selR     <= cfgWrData[16 +: SEL_W];
      end
      if (strobe.ldCnt) begin
        conv   <= conv_e'(cfgWrData[28:27]);
        srcInc <= cfgWrData[29];
        dstInc <= cfgWrData[30];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      doneFlag   <= 1'b0;
      errFlag    <= 1'b0;
      fencePulse <= 1'b0;
    end else begin
      fencePulse <= 1'b0;
      unique case (state)
        ST_IDLE: if (startGo) begin
          state    <= ST_READ;
          doneFlag <= 1'b0;
          errFlag  <= 1'b0;
        end
        ST_READ: if (busErr) begin
          state   <= ST_IDLE;
          errFlag <= 1'b1;
        end else if (busAck) begin
          state <= ST_WRITE;
        end
        ST_WRITE: if (busErr) begin
          state   <= ST_IDLE;
          errFlag <= 1'b1;
        end else if (busAck) begin
          if (lastElem) begin
            state      <= ST_IDLE;
            doneFlag   <= 1'b1;
            fencePulse <= fenceBit;
          end else begin
            state <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrlWord        = '0;
    ctrlWord[0]     = enBit;
    ctrlWord[1]     = autoBit;
    ctrlWord[2]     = fenceBit;
    ctrlWord[8]     = busy;
    ctrlWord[9]     = doneFlag;
    ctrlWord[10]    = errFlag;
    ctrlWord[15]    = lvlBit;
    ctrlWord[19:16] = 4'(selR);
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && !busErr |=> busReq && $stable(busWe));

  // R10
  fence_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fencePulse |=> !fencePulse);

  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && busErr |=> !busReq && !fencePulse);

  // R13
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busReq ##1 busReq |-> !ctrlWord[9] && !ctrlWord[10]);

endmodule

// File: rtl/xdma_top.sv
module xdma_top
  import xdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 24,
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWrEn,
  input  logic [1:0]     cfgIdx,
  input  logic [31:0]    cfgWrData,
  output logic [31:0]    cfgRdData,
  input  logic [NCH-1:0] irqLines,
  output logic           busReq,
  output logic           busWe,
  output logic           busWord,
  output logic [AW-1:0]  busAddr,
  output logic [31:0]    busWdata,
  input  logic [31:0]    busRdata,
  input  logic           busAck,
  input  logic           busErr,
  output logic           fencePulse
);

  dp_strobe_t    strobe;
  conv_e         conv;
  logic          srcInc, dstInc;
  logic [AW-1:0] srcPtr, dstPtr;
  logic [CW-1:0] remain;
  logic [31:0]   ctrlWord;
  logic [31:0]   typeWord;

  xdma_ctrl #(.CW(CW), .NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgWrData(cfgWrData), .irqLines(irqLines), .busAck(busAck),
    .busErr(busErr), .remain(remain), .strobe(strobe), .conv(conv),
    .srcInc(srcInc), .dstInc(dstInc), .busReq(busReq), .busWe(busWe),
    .busWord(busWord), .fencePulse(fencePulse), .ctrlWord(ctrlWord)
  );

  xdma_datapath #(.AW(AW), .CW(CW), .DW(32)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(cfgWrData),
    .conv(conv), .srcInc(srcInc), .dstInc(dstInc), .busRdata(busRdata),
    .srcPtr(srcPtr), .dstPtr(dstPtr), .remain(remain), .wrWord(busWdata)
  );

  assign busAddr = busWe ? dstPtr : srcPtr;

  always_comb begin
    typeWord        = '0;
    typeWord[CW-1:0] = remain;
    typeWord[28:27] = conv;
    typeWord[29]    = srcInc;
    typeWord[30]    = dstInc;
  end

  always_comb begin
    unique case (cfgIdx)
      REG_CTRL: cfgRdData = ctrlWord;
      REG_SRC:  cfgRdData = 32'(srcPtr);
      REG_DST:  cfgRdData = 32'(dstPtr);
      default:  cfgRdData = typeWord;
    endcase
  end

  // R12
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck && !busErr |=> $stable(busAddr));

endmodule

// File: tb/xdma_top_tb.sv
module xdma_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgIdx = 2'd0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic [15:0] irqLines = '0;
  logic        busReq, busWe, busWord, fencePulse;
  logic [31:0] busAddr, busWdata;
  logic [31:0] busRdata = '0;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;

  int nTests = 0;
  int nFail = 0;
  int fenceCnt = 0;
  int latency = 0;
  logic        errArm = 1'b0;
  logic [7:0]  errAddr = 8'h00;
  logic [7:0]  mem [0:255];

  always #2 clk = ~clk;

  xdma_top u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .irqLines(irqLines),
    .busReq(busReq), .busWe(busWe), .busWord(busWord), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck),
    .busErr(busErr), .fencePulse(fencePulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // bus slave: byte memory, optional wait states, optional error address
  initial begin
    int waitCnt;
    logic [7:0] a;
    waitCnt = 0;
    forever begin
      @(negedge clk);
      if (busAck || busErr) begin
        busAck = 1'b0;
        busErr = 1'b0;
      end else if (busReq === 1'b1) begin
        if (waitCnt < latency) waitCnt++;
        else begin
          waitCnt = 0;
          a = busAddr[7:0];
          if (errArm && a == errAddr) busErr = 1'b1;
          else begin
            busAck = 1'b1;
            if (busWe) begin
              mem[a] = busWdata[7:0];
              if (busWord) begin
                mem[8'(a+1)] = busWdata[15:8];
                mem[8'(a+2)] = busWdata[23:16];
                mem[8'(a+3)] = busWdata[31:24];
              end
            end else if (busWord)
              busRdata = {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
            else
              busRdata = {24'h0, mem[a]};
          end
        end
      end
    end
  end

  // R12: pending request must hold address and direction
  initial begin
    logic pend;
    logic [31:0] pAddr;
    logic pWe;
    pend = 1'b0;
    pAddr = '0;
    pWe = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (pend) begin
        check("R12 req held", {31'h0, busReq}, 32'h1);
        check("R12 addr stable", busAddr, pAddr);
        check("R12 dir stable", {31'h0, busWe}, {31'h0, pWe});
      end
      pend  = (busReq === 1'b1) && !busAck && !busErr;
      pAddr = busAddr;
      pWe   = busWe;
    end
  end

  initial forever begin
    @(posedge clk);
    if (fencePulse === 1'b1) fenceCnt++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    cfgIdx = idx;
    #1 d = cfgRdData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(2'd0, v);
      if (!v[8]) break;
    end
  endtask

  function automatic logic [31:0] memWord(input logic [7:0] a);
    return {mem[8'(a+3)], mem[8'(a+2)], mem[8'(a+1)], mem[a]};
  endfunction

  localparam logic [31:0] T_SI = 32'h2000_0000;
  localparam logic [31:0] T_DI = 32'h4000_0000;

  task automatic runCopy(input logic [31:0] ctrl, input logic [31:0] src,
                         input logic [31:0] dst, input logic [31:0] typ);
    wr(2'd0, ctrl);
    wr(2'd1, src);
    wr(2'd2, dst);
    fenceCnt = 0;
    wr(2'd3, typ);
    waitIdle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int r = 0; r < 4; r++) begin
      rd(2'(r), v);
      check("R1 reg zero after reset", v, 32'h0);
    end
    check("R1 no request", {31'h0, busReq}, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v);
    check("R2 ctrl reserved zero", v, 32'h000F_8007);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v);
    check("R2 type reserved zero", v, 32'h78FF_FFFF);
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h0);
    rd(2'd3, v);
    check("R2 type cleared", v, 32'h0);
  endtask

  task automatic t_byteCopy();
    logic [31:0] v;
    runCopy(32'h5, 32'h10, 32'h80, T_SI | T_DI | 32'd4);
    check("R3 byte copy data", memWord(8'h80),
          {8'h13 ^ 8'h5A, 8'h12 ^ 8'h5A, 8'h11 ^ 8'h5A, 8'h10 ^ 8'h5A});
    check("R3 no overrun", {24'h0, mem[8'h84]}, {24'h0, 8'h84 ^ 8'h5A});
    rd(2'd1, v); check("R5 src stepped by 1", v, 32'h14);
    rd(2'd2, v); check("R5 dst stepped by 1", v, 32'h84);
    rd(2'd3, v); check("R6 remaining zero", v, 32'h6000_0000);
    rd(2'd0, v); check("R3 done set busy clear", v, 32'h0000_0205);
    check("R10 one fence pulse", fenceCnt, 1);
  endtask

  task automatic t_zeroExt();
    logic [31:0] v;
    mem[8'h20] = 8'h85;
    mem[8'h21] = 8'h11;
    runCopy(32'h1, 32'h20, 32'h40, T_SI | T_DI | (32'd1 << 27) | 32'd2);
    check("R4 zero extend 0x85", memWord(8'h40), 32'h0000_0085);
    check("R4 zero extend 0x11", memWord(8'h44), 32'h0000_0011);
    rd(2'd1, v); check("R5 byte source step", v, 32'h22);
    rd(2'd2, v); check("R5 word dest step", v, 32'h48);
    check("R10 no fence when disabled", fenceCnt, 0);
  endtask

  task automatic t_signExt();
    runCopy(32'h1, 32'h20, 32'h50, T_SI | T_DI | (32'd2 << 27) | 32'd1);
    check("R4 sign extend 0x85", memWord(8'h50), 32'hFFFF_FF85);
  endtask

  task automatic t_wordConstSrc();
    logic [31:0] v;
    {mem[8'h33], mem[8'h32], mem[8'h31], mem[8'h30]} = 32'hDEAD_BEEF;
    latency = 2;
    runCopy(32'h1, 32'h30, 32'h60, T_DI | (32'd3 << 27) | 32'd3);
    latency = 0;
    check("R4 word copy 0", memWord(8'h60), 32'hDEAD_BEEF);
    check("R4 word copy 2", memWord(8'h68), 32'hDEAD_BEEF);
    rd(2'd1, v); check("R5 constant source", v, 32'h30);
    rd(2'd2, v); check("R5 dest step 4", v, 32'h6C);
  endtask

  task automatic t_constDst();
    logic [31:0] v;
    runCopy(32'h1, 32'h10, 32'h9F, T_SI | 32'd3);
    check("R5 constant dest last byte", {24'h0, mem[8'h9F]}, {24'h0, 8'h12 ^ 8'h5A});
    check("R5 neighbour untouched", {24'h0, mem[8'hA0]}, {24'h0, 8'hA0 ^ 8'h5A});
    rd(2'd2, v); check("R5 dest pointer fixed", v, 32'h9F);
  endtask

  task automatic t_busyWrites();
    logic [31:0] v;
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h10);
    wr(2'd2, 32'hB0);
    wr(2'd3, T_SI | T_DI | 32'd4);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
    wr(2'd3, 32'h7);
    waitIdle();
    rd(2'd1, v); check("R11 src write ignored", v, 32'h14);
    rd(2'd2, v); check("R11 dst write ignored", v, 32'hB4);
    rd(2'd3, v); check("R11 type write ignored", v, 32'h6000_0000);
    check("R11 copy intact", {24'h0, mem[8'hB3]}, {24'h0, 8'h13 ^ 8'h5A});
  endtask

  task automatic t_busError();
    logic [31:0] v;
    errAddr = 8'h11;
    errArm = 1'b1;
    runCopy(32'h5, 32'h10, 32'hC0, T_SI | T_DI | 32'd4);
    errArm = 1'b0;
    rd(2'd0, v); check("R9 error set, done clear", v, 32'h0000_0405);
    rd(2'd3, v); check("R9 count frozen", v, 32'h6000_0003);
    rd(2'd1, v); check("R9 src at failing element", v, 32'h11);
    check("R9 first element copied", {24'h0, mem[8'hC0]}, {24'h0, 8'h10 ^ 8'h5A});
    check("R9 second untouched", {24'h0, mem[8'hC1]}, {24'h0, 8'hC1 ^ 8'h5A});
    check("R9 no fence on error", fenceCnt, 0);
    check("R9 request dropped", {31'h0, busReq}, 32'h0);
  endtask

  task automatic t_clearSticky();
    logic [31:0] v;
    runCopy(32'h1, 32'h10, 32'hD0, T_SI | T_DI | 32'd1);
    rd(2'd0, v); check("R13 error cleared by start", v, 32'h0000_0201);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(2'd0, 32'h0);
    irqLines[5] = 1'b1;
    wr(2'd1, 32'h10);
    wr(2'd2, 32'hE0);
    wr(2'd3, T_SI | T_DI | 32'd2);
    wr(2'd0, 32'h0005_0003);
    repeat (5) @(negedge clk);
    rd(2'd3, v); check("R7 high line gives no edge", v, 32'h6000_0002);
    irqLines[3] = 1'b1;
    repeat (5) @(negedge clk);
    irqLines[3] = 1'b0;
    rd(2'd3, v); check("R7 other channel ignored", v, 32'h6000_0002);
    irqLines[5] = 1'b0;
    repeat (2) @(negedge clk);
    irqLines[5] = 1'b1;
    repeat (2) @(negedge clk);
    waitIdle();
    irqLines[5] = 1'b0;
    rd(2'd3, v); check("R7 edge started copy", v, 32'h6000_0000);
    check("R7 data moved", {16'h0, mem[8'hE1], mem[8'hE0]},
          {16'h0, 8'h11 ^ 8'h5A, 8'h10 ^ 8'h5A});
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(2'd0, 32'h0);
    irqLines[9] = 1'b1;
    wr(2'd1, 32'h10);
    wr(2'd2, 32'hF0);
    wr(2'd3, T_SI | T_DI | 32'd1);
    wr(2'd0, 32'h0009_8003);
    repeat (2) @(negedge clk);
    waitIdle();
    check("R8 level started copy", {24'h0, mem[8'hF0]}, {24'h0, 8'h10 ^ 8'h5A});
    repeat (10) @(negedge clk);
    rd(2'd2, v); check("R8 no restart with zero count", v, 32'hF1);
    irqLines[9] = 1'b0;
    wr(2'd0, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_byteCopy();
    t_zeroExt();
    t_signExt();
    t_wordConstSrc();
    t_constDst();
    t_busyWrites();
    t_busError();
    t_clearSticky();
    t_edge();
    t_level();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule